// File: doc/BRIEF.md
# Regulator Start-up and Power-Good Sequencer

This block decides when a step-down regulator may begin its soft-start ramp, when the power switch may start toggling, and when the power-good indication may be released. The analog parts around it are represented as digital flags. A supply-healthy bit and an enable bit gate start-up. Three comparator flags report the soft-start capacitor level: at zero, past the level at which switching may begin, and past the level that ends the ramp. A fault line comes from the protection supervisor. Two window-comparator bits report whether the fed-back output is under or over its regulation window.

Switching begins part way up the ramp. Power-good stays deasserted for the whole ramp and is released only once the ramp has ended and the filtered window comparators report the output in range. A fault stops switching and discharges the soft-start node. When the fault clears, the block makes a fresh start from a fully discharged capacitor. If the supply drops while the regulator is starting or running, it is latched off. Only a fresh rising edge of the supply bit or a low level on enable releases that latch.

Top module: `startup_pg_seq`

## Requirements
- R1: While reset is high, and in the idle state, the outputs are ss_discharge_o=1, ss_charge_o=0, sw_enable_o=0 and pgood_n_o=1.
- R2: From idle, ss_charge_o rises (and ss_discharge_o falls) one clock after a cycle in which por_ok_i, enable_i and ss_zero_i are all 1. No start is taken while ss_zero_i is 0.
- R3: While charging, sw_enable_o rises one clock after ss_sw_lvl_i is seen high. It never rises at any other time.
- R4: While charging with switching on, the block enters regulation one clock after ss_end_lvl_i is seen high. pgood_n_o can be 0 only in regulation, and only while both filtered window bits are 0.
- R5: Each window bit passes through SYNC_STAGES synchronising flops and a filter that takes a new value only after DEB_CYCLES consecutive samples differ from it. With the defaults (2, 4), a level change driven before clock edge k shows on pgood_n_o after edge k+5. A pulse shorter than 4 cycles has no effect.
- R6: In regulation, a filtered under-window (fb_under_i) or over-window (fb_over_i) condition sets pgood_n_o to 1 while switching continues. pgood_n_o returns to 0 when both filtered bits are 0 again.
- R7: fault_i high during the ramp or regulation stops switching and charging, asserts discharge and sets pgood_n_o to 1 on the next clock. This holds while fault_i stays high. After fault_i clears, the block passes through idle and restarts only per R2.
- R8: enable_i low in any state returns the block to idle on the next clock (outputs as in R1).
- R9: por_ok_i low during the ramp, regulation or a fault latches the regulator off (outputs as in R1). The latch is left only on a later rising edge of por_ok_i or on enable_i low. A restart then needs one idle cycle before charging.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| por_ok_i | input | 1 | Supply above its power-on-reset threshold |
| enable_i | input | 1 | Regulator enable |
| ss_zero_i | input | 1 | Soft-start node fully discharged |
| ss_sw_lvl_i | input | 1 | Soft-start level past the switching threshold |
| ss_end_lvl_i | input | 1 | Soft-start level past the end-of-ramp threshold |
| fault_i | input | 1 | Shutdown request from the fault supervisor |
| fb_under_i | input | 1 | Feedback below regulation window (asynchronous) |
| fb_over_i | input | 1 | Feedback above regulation window (asynchronous) |
| ss_charge_o | output | 1 | Enable soft-start charge current |
| ss_discharge_o | output | 1 | Discharge soft-start node |
| sw_enable_o | output | 1 | Allow power switch to toggle |
| pgood_n_o | output | 1 | Power-good, active low |

## Verification
The hardest state to reach from the ports is the supply-loss latch, because it only differs from plain idle in how it is left. The stimulus drops por_ok_i during the ramp while enable_i stays high and holds the supply low for several cycles. It then restores the supply and watches for the extra idle cycle before charging resumes. The window filter is driven both with pulses shorter than the debounce length and with stable levels. A behavioural model, compared on every clock, pins down the exact release and withdrawal cycle of power-good.

// File: rtl/startup_pg_seq_pkg.sv
package startup_pg_seq_pkg;

    typedef enum logic [2:0] {
        ST_OFF         = 3'd0,
        ST_SS_PRE      = 3'd1,
        ST_SS_RUN      = 3'd2,
        ST_REGULATING  = 3'd3,
        ST_FAULT       = 3'd4,
        ST_LATCHED_OFF = 3'd5
    } seq_state_e;

    typedef struct packed {
        logic charge;
        logic discharge;
        logic switch_en;
        logic pg_allow;
    } seq_ctrl_t;

    typedef struct packed {
        logic under;
        logic over;
    } win_bits_t;

    localparam int WIN_BITS = $bits(win_bits_t);

    // Control pattern for each sequencer state
    function automatic seq_ctrl_t state_ctrl(input seq_state_e st);
        seq_ctrl_t c;
        c = '{charge: 1'b0, discharge: 1'b1, switch_en: 1'b0, pg_allow: 1'b0};
        case (st)
            ST_SS_PRE:     c = '{charge: 1'b1, discharge: 1'b0, switch_en: 1'b0, pg_allow: 1'b0};
            ST_SS_RUN:     c = '{charge: 1'b1, discharge: 1'b0, switch_en: 1'b1, pg_allow: 1'b0};
            ST_REGULATING: c = '{charge: 1'b1, discharge: 1'b0, switch_en: 1'b1, pg_allow: 1'b1};
            default:       c = '{charge: 1'b0, discharge: 1'b1, switch_en: 1'b0, pg_allow: 1'b0};
        endcase
        return c;
    endfunction

    function automatic logic in_window(input win_bits_t w);
        return !(w.under || w.over);
    endfunction

    function automatic logic is_active(input seq_state_e st);
        return (st == ST_SS_PRE) || (st == ST_SS_RUN) ||
               (st == ST_REGULATING) || (st == ST_FAULT);
    endfunction

endpackage

// File: rtl/seq_sync_filter.sv
module seq_sync_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int DEB_CYCLES  = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic raw_i,
    output logic filt_o
);
    localparam int CW = $clog2(DEB_CYCLES + 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic [CW-1:0]          cnt_q;
    logic                   filt_q;
    logic                   synced;

    generate
        if (SYNC_STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '0;
                else     sync_q <= raw_i;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '0;
                else     sync_q <= {sync_q[SYNC_STAGES-2:0], raw_i};
            end
        end
    endgenerate

    assign synced = sync_q[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            filt_q <= 1'b0;
        end else if (synced == filt_q) begin
            cnt_q <= '0;
        end else if (cnt_q == CW'(DEB_CYCLES - 1)) begin
            cnt_q  <= '0;
            filt_q <= synced;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign filt_o = filt_q;
endmodule

// File: rtl/seq_fsm.sv
module seq_fsm
    import startup_pg_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       por_ok_i,
    input  logic       enable_i,
    input  logic       ss_zero_i,
    input  logic       ss_sw_lvl_i,
    input  logic       ss_end_lvl_i,
    input  logic       fault_i,
    output seq_state_e state_o
);
    seq_state_e state_q, state_d;
    logic       por_q;
    logic       por_rise;

    assign por_rise = por_ok_i && !por_q;

    always_comb begin
        state_d = state_q;
        if (is_active(state_q)) begin
            // supply loss dominates, then enable, then fault
            if (!por_ok_i)        state_d = ST_LATCHED_OFF;
            else if (!enable_i)   state_d = ST_OFF;
            else if (state_q == ST_FAULT) begin
                if (!fault_i)     state_d = ST_OFF;
            end else if (fault_i) state_d = ST_FAULT;
            else if (state_q == ST_SS_PRE && ss_sw_lvl_i)  state_d = ST_SS_RUN;
            else if (state_q == ST_SS_RUN && ss_end_lvl_i) state_d = ST_REGULATING;
        end else if (state_q == ST_LATCHED_OFF) begin
            if (!enable_i || por_rise) state_d = ST_OFF;
        end else begin
            if (por_ok_i && enable_i && ss_zero_i) state_d = ST_SS_PRE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_OFF;
            por_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            por_q   <= por_ok_i;
        end
    end

    assign state_o = state_q;
endmodule

// File: rtl/seq_outdec.sv
module seq_outdec
    import startup_pg_seq_pkg::*;
(
    input  seq_state_e state_i,
    input  win_bits_t  win_i,
    output logic       ss_charge_o,
    output logic       ss_discharge_o,
    output logic       sw_enable_o,
    output logic       pgood_n_o
);
    seq_ctrl_t ctrl;

    always_comb begin
        ctrl           = state_ctrl(state_i);
        ss_charge_o    = ctrl.charge;
        ss_discharge_o = ctrl.discharge;
        sw_enable_o    = ctrl.switch_en;
        pgood_n_o      = !(ctrl.pg_allow && in_window(win_i));
    end
endmodule

// File: rtl/startup_pg_seq.sv
module startup_pg_seq
    import startup_pg_seq_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int DEB_CYCLES  = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic por_ok_i,
    input  logic enable_i,
    input  logic ss_zero_i,
    input  logic ss_sw_lvl_i,
    input  logic ss_end_lvl_i,
    input  logic fault_i,
    input  logic fb_under_i,
    input  logic fb_over_i,
    output logic ss_charge_o,
    output logic ss_discharge_o,
    output logic sw_enable_o,
    output logic pgood_n_o
);
    logic [WIN_BITS-1:0] win_raw;
    logic [WIN_BITS-1:0] win_filt;
    win_bits_t           win_s;
    seq_state_e          state;

    assign win_raw = {fb_under_i, fb_over_i};

    generate
        for (genvar b = 0; b < WIN_BITS; b++) begin : g_win
            seq_sync_filter #(
                .SYNC_STAGES(SYNC_STAGES),
                .DEB_CYCLES (DEB_CYCLES)
            ) u_filt (
                .clk   (clk),
                .rst   (rst),
                .raw_i (win_raw[b]),
                .filt_o(win_filt[b])
            );
        end
    endgenerate

    assign win_s = win_bits_t'(win_filt);

    seq_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .por_ok_i    (por_ok_i),
        .enable_i    (enable_i),
        .ss_zero_i   (ss_zero_i),
        .ss_sw_lvl_i (ss_sw_lvl_i),
        .ss_end_lvl_i(ss_end_lvl_i),
        .fault_i     (fault_i),
        .state_o     (state)
    );

    seq_outdec u_dec (
        .state_i       (state),
        .win_i         (win_s),
        .ss_charge_o   (ss_charge_o),
        .ss_discharge_o(ss_discharge_o),
        .sw_enable_o   (sw_enable_o),
        .pgood_n_o     (pgood_n_o)
    );
endmodule

// File: rtl/startup_pg_seq_chk.sv
module startup_pg_seq_chk (
    input logic clk,
    input logic rst,
    input logic por_ok_i,
    input logic enable_i,
    input logic ss_zero_i,
    input logic ss_sw_lvl_i,
    input logic fault_i,
    input logic ss_charge_o,
    input logic ss_discharge_o,
    input logic sw_enable_o,
    input logic pgood_n_o
);
    // R1
    reset_idle_chk: assert property (@(posedge clk)
        rst |=> (ss_discharge_o && !ss_charge_o && !sw_enable_o && pgood_n_o));

    // R2
    start_from_zero_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ss_charge_o) |-> ($past(ss_zero_i) && $past(enable_i) && $past(por_ok_i)));

    // R3
    switch_threshold_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sw_enable_o) |-> $past(ss_sw_lvl_i));

    // R4
    pgood_needs_run_chk: assert property (@(posedge clk) disable iff (rst)
        !pgood_n_o |-> (sw_enable_o && ss_charge_o && !ss_discharge_o));

    // R7
    fault_stop_chk: assert property (@(posedge clk) disable iff (rst)
        fault_i |=> (!sw_enable_o && pgood_n_o && !ss_charge_o));

    // R8
    enable_off_chk: assert property (@(posedge clk) disable iff (rst)
        !enable_i |=> (ss_discharge_o && !sw_enable_o && pgood_n_o));

    // R9
    supply_loss_chk: assert property (@(posedge clk) disable iff (rst)
        (!por_ok_i && ss_charge_o) |=> (!ss_charge_o && !sw_enable_o && ss_discharge_o));
endmodule

bind startup_pg_seq startup_pg_seq_chk chk_i (
    .clk           (clk),
    .rst           (rst),
    .por_ok_i      (por_ok_i),
    .enable_i      (enable_i),
    .ss_zero_i     (ss_zero_i),
    .ss_sw_lvl_i   (ss_sw_lvl_i),
    .fault_i       (fault_i),
    .ss_charge_o   (ss_charge_o),
    .ss_discharge_o(ss_discharge_o),
    .sw_enable_o   (sw_enable_o),
    .pgood_n_o     (pgood_n_o)
);

// File: tb/startup_pg_seq_tb_top.sv
module startup_pg_seq_tb_top;
    localparam int SYNC = 2;
    localparam int DEB  = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic por = 1'b0, en = 1'b0, ssz = 1'b1, ssw = 1'b0, sse = 1'b0;
    logic flt = 1'b0, fbu = 1'b0, fbo = 1'b0;
    logic chg, dis, swe, pgn;

    int    compared   = 0;
    int    mismatched = 0;
    bit    done       = 1'b0;
    string cur_req    = "R1";

    always #2 clk = ~clk;   // 250 MHz

    startup_pg_seq #(.SYNC_STAGES(SYNC), .DEB_CYCLES(DEB)) dut_i (
        .clk(clk), .rst(rst), .por_ok_i(por), .enable_i(en),
        .ss_zero_i(ssz), .ss_sw_lvl_i(ssw), .ss_end_lvl_i(sse),
        .fault_i(flt), .fb_under_i(fbu), .fb_over_i(fbo),
        .ss_charge_o(chg), .ss_discharge_o(dis),
        .sw_enable_o(swe), .pgood_n_o(pgn)
    );

    // behavioural reference: 0 idle,1 ramp-quiet,2 ramp-switching,3 regulate,4 fault,5 latched
    int m_st = 0;
    bit m_porq = 0;
    bit q_u[$];
    bit q_o[$];
    bit f_u = 0, f_o = 0;
    int c_u = 0, c_o = 0;

    initial begin
        for (int i = 0; i < SYNC; i++) begin q_u.push_back(0); q_o.push_back(0); end
    end

    always @(posedge clk) begin
        if (rst) begin
            m_st = 0; m_porq = 0; f_u = 0; f_o = 0; c_u = 0; c_o = 0;
            q_u = {}; q_o = {};
            for (int i = 0; i < SYNC; i++) begin q_u.push_back(0); q_o.push_back(0); end
        end else begin
            int nx;
            bit su, so;
            nx = m_st;
            if (m_st >= 1 && m_st <= 4) begin
                if (!por) nx = 5;
                else if (!en) nx = 0;
                else if (m_st == 4) begin if (!flt) nx = 0; end
                else if (flt) nx = 4;
                else if (m_st == 1 && ssw) nx = 2;
                else if (m_st == 2 && sse) nx = 3;
            end else if (m_st == 5) begin
                if (!en || (por && !m_porq)) nx = 0;
            end else if (por && en && ssz) nx = 1;
            m_st = nx;
            m_porq = por;
            su = q_u[SYNC-1];
            so = q_o[SYNC-1];
            if (su == f_u) c_u = 0;
            else if (c_u == DEB-1) begin f_u = su; c_u = 0; end
            else c_u++;
            if (so == f_o) c_o = 0;
            else if (c_o == DEB-1) begin f_o = so; c_o = 0; end
            else c_o++;
            q_u.push_front(fbu); void'(q_u.pop_back());
            q_o.push_front(fbo); void'(q_o.pop_back());
        end
    end

    always @(negedge clk) begin
        if (!done) begin
            logic ec, ed, es, ep;
            ec = (m_st >= 1 && m_st <= 3);
            ed = !ec;
            es = (m_st == 2 || m_st == 3);
            ep = !(m_st == 3 && !f_u && !f_o);
            compared++;
            if ({chg, dis, swe, pgn} !== {ec, ed, es, ep}) begin
                mismatched++;
                $display("FAIL %s t=%0t chg/dis/sw/pgn actual=%b%b%b%b expected=%b%b%b%b",
                         cur_req, $time, chg, dis, swe, pgn, ec, ed, es, ep);
            end
        end
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run;
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    task automatic ramp_up;
        // R2 start, R3 switching, R4 regulation
        cur_req = "R2"; ssz = 1; wait_cyc(2); ssz = 0; wait_cyc(3);
        cur_req = "R3"; ssw = 1; wait_cyc(4);
        cur_req = "R4"; sse = 1; wait_cyc(4);
    endtask

    initial begin
        // R1: reset and idle
        cur_req = "R1";
        wait_cyc(3); rst = 0; wait_cyc(3);
        por = 1; wait_cyc(3);
        // R2: enable while soft-start not at zero must not start
        cur_req = "R2"; ssz = 0; en = 1; wait_cyc(4);
        ramp_up();
        // R5: short pulses ignored
        cur_req = "R5"; fbu = 1; wait_cyc(2); fbu = 0; wait_cyc(8);
        fbo = 1; wait_cyc(3); fbo = 0; wait_cyc(8);
        // R6: stable under then over window
        cur_req = "R6"; fbu = 1; wait_cyc(10); fbu = 0; wait_cyc(10);
        fbo = 1; wait_cyc(10); fbo = 0; wait_cyc(10);
        // R7: fault during regulation, then restart
        cur_req = "R7"; flt = 1; wait_cyc(5); ssw = 0; sse = 0; ssz = 1; wait_cyc(2);
        flt = 0; wait_cyc(3);
        ssz = 0; wait_cyc(2); ssw = 1; wait_cyc(2);
        flt = 1; wait_cyc(3); flt = 0; ssw = 0; ssz = 1; wait_cyc(4);
        ramp_up();
        // R8: enable low in regulation
        cur_req = "R8"; en = 0; wait_cyc(4); sse = 0; ssw = 0; ssz = 1; en = 1; wait_cyc(3);
        // R9: supply loss during the ramp latches off
        cur_req = "R9"; ssz = 0; wait_cyc(2); ssw = 1; wait_cyc(2);
        por = 0; wait_cyc(2); ssw = 0; ssz = 1; wait_cyc(4);
        por = 1; wait_cyc(6);
        // R9: latch released by enable low
        ssz = 0; wait_cyc(2); por = 0; wait_cyc(3); por = 1; ssz = 0; wait_cyc(2);
        en = 0; wait_cyc(2); ssz = 1; en = 1; wait_cyc(4);
        // R1: idle again with enable low
        cur_req = "R1"; en = 0; wait_cyc(5);
        finish_run();
    end
endmodule